// File: doc/BRIEF.md
# Indexed-Mode Bus Cycle Sequencer

This block produces the bus activity, one cycle at a time, of an 8-bit processor running an instruction that uses indexed addressing. A start strobe brings in an instruction class, the address of the opcode and the 16-bit index register. From then on, each clock cycle the block drives one bus cycle: an address, a read/write line and write data. It samples the byte the memory returns at the end of every read cycle.

The effective address is the index plus the unsigned offset byte that follows the opcode. Every class first fetches the opcode and the offset. It then inserts one dummy cycle on the all-ones address. After that comes a fixed, class-specific mix of operand reads, further dummy cycles and writes. The block keeps the opcode, the effective address and the operand bytes it has read. A one-cycle done flag marks the final bus cycle. The result of a read-modify-write comes from an external arithmetic unit through a dedicated input.

Top module: `idx_bus_seq`

## Requirements
- R1: The first bus cycle reads the opcode address and the second reads opcode address + 1, both with `rw_o` high. The byte read in the first cycle is held on `opcode_o` once the instruction ends.
- R2: The third cycle of every class is a read of address 16'hFFFF whose data is discarded. While idle, the bus shows address 16'hFFFF with `rw_o` high.
- R3: The effective address is the index plus the offset byte taken as unsigned and zero-extended, modulo 65536. It appears on `eff_addr_o` from the third cycle on and stays stable until the next offset fetch.
- R4: Class codes and lengths are: 0 jump, 3 cycles; 1 byte read, 4 cycles; 2 byte store, 4 cycles; 3 word load, 5 cycles; 4 read-modify-write, 6 cycles; 5 test, 6 cycles. Codes 6 and 7 run the 3-cycle jump sequence.
- R5: A byte read reads the effective address in cycle 4. After the instruction, `operand_o` holds {8'h00, byte}.
- R6: A byte store writes, in cycle 4, the `acc_i` value present when start was accepted to the effective address, with `rw_o` low.
- R7: A word load reads the high byte at the effective address in cycle 4 and the low byte at effective address + 1 (wrapping) in cycle 5. `operand_o` then holds {high, low}.
- R8: A read-modify-write reads the effective address in cycle 4, reads 16'hFFFF in cycle 5 and writes in cycle 6 to the same address. The data written is the `rmw_i` value sampled at the end of cycle 5.
- R9: A test instruction follows the same first five cycles as read-modify-write, but its cycle 6 is a second read of 16'hFFFF and it never drives `rw_o` low.
- R10: `done_o` is high for exactly one cycle, the final bus cycle. `busy_o` is high from the first to the final cycle and low in the following cycle.
- R11: A start is accepted only while `busy_o` is low, and its first bus cycle appears in the next cycle. A start during an instruction has no effect on the bus sequence.
- R12: `wdata_o` is zero in every cycle where `rw_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an instruction (accepted while idle) |
| class_i | input | 3 | Instruction class code |
| op_addr_i | input | 16 | Address of the opcode byte |
| index_i | input | 16 | Index register value |
| acc_i | input | 8 | Accumulator byte for stores |
| rmw_i | input | 8 | Modified operand from the arithmetic unit |
| din_i | input | 8 | Byte returned by memory for the current bus cycle |
| addr_o | output | 16 | Bus address |
| rw_o | output | 1 | High for read, low for write |
| wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Final bus cycle of the instruction |
| opcode_o | output | 8 | Captured opcode byte |
| eff_addr_o | output | 16 | Index plus offset |
| operand_o | output | 16 | Captured operand byte(s) |

## Verification
The assertions assume that `din_i` is a function of the address currently on the bus, and that `rst` is held high until the first clock edge. They also assume that `rmw_i` stays stable from start until done, so that the value written matches what the arithmetic unit produced. The stimulus uses a memory model that computes each byte from its address and returns the chosen offset only at opcode address + 1. It picks addresses where the effective address never lands on that location, and holds `rmw_i` for the whole instruction. Each call changes `acc_i` right after start, so that latching at start is exercised. Extra starts are raised only in the middle of an instruction.

// File: rtl/idxseq_pkg.sv
package idxseq_pkg;
  localparam int CLS_W = 3;
  localparam int CYC_W = 3;

  localparam logic [CLS_W-1:0] CL_JMP  = 3'd0;
  localparam logic [CLS_W-1:0] CL_RD8  = 3'd1;
  localparam logic [CLS_W-1:0] CL_ST8  = 3'd2;
  localparam logic [CLS_W-1:0] CL_LD16 = 3'd3;
  localparam logic [CLS_W-1:0] CL_RMW  = 3'd4;
  localparam logic [CLS_W-1:0] CL_TST  = 3'd5;

  // kind of bus cycle
  typedef enum logic [2:0] {
    K_IDLE, K_OPC, K_OFS, K_DUM, K_RD8, K_RDH, K_RDL, K_WR
  } kind_t;

  function automatic logic [CYC_W-1:0] seq_len(input logic [CLS_W-1:0] c);
    case (c)
      CL_RD8, CL_ST8: seq_len = 3'd4;
      CL_LD16:        seq_len = 3'd5;
      CL_RMW, CL_TST: seq_len = 3'd6;
      default:        seq_len = 3'd3;
    endcase
  endfunction

  function automatic kind_t seq_kind(input logic [CLS_W-1:0] c,
                                     input logic [CYC_W-1:0] n);
    seq_kind = K_IDLE;
    case (n)
      3'd1: seq_kind = K_OPC;
      3'd2: seq_kind = K_OFS;
      3'd3: seq_kind = K_DUM;
      3'd4: case (c)
              CL_RD8, CL_RMW, CL_TST: seq_kind = K_RD8;
              CL_ST8:                 seq_kind = K_WR;
              CL_LD16:                seq_kind = K_RDH;
              default:                seq_kind = K_IDLE;
            endcase
      3'd5: case (c)
              CL_LD16:        seq_kind = K_RDL;
              CL_RMW, CL_TST: seq_kind = K_DUM;
              default:        seq_kind = K_IDLE;
            endcase
      3'd6: case (c)
              CL_RMW:  seq_kind = K_WR;
              CL_TST:  seq_kind = K_DUM;
              default: seq_kind = K_IDLE;
            endcase
      default: seq_kind = K_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/idxseq_plan.sv
module idxseq_plan
  import idxseq_pkg::*;
(
  input  logic [CLS_W-1:0] cls_i,
  input  logic [CYC_W-1:0] cyc_i,
  output kind_t            kind_o,
  output logic             last_o
);
  always_comb begin
    kind_o = seq_kind(cls_i, cyc_i);
    last_o = (cyc_i != '0) && (cyc_i == seq_len(cls_i));
  end
endmodule

// File: rtl/idxseq_agen.sv
module idxseq_agen
  import idxseq_pkg::*;
#(
  parameter int AW = 16
) (
  input  kind_t          kind_i,
  input  logic [AW-1:0]  opa_i,
  input  logic [AW-1:0]  ea_i,
  output logic [AW-1:0]  addr_o,
  output logic           rd_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_comb begin
    case (kind_i)
      K_OPC:               addr_o = opa_i;
      K_OFS:               addr_o = opa_i + ONE;
      K_RD8, K_RDH, K_WR:  addr_o = ea_i;
      K_RDL:               addr_o = ea_i + ONE;
      default:             addr_o = '1;
    endcase
    rd_o = (kind_i != K_WR);
  end
endmodule

// File: rtl/idxseq_capture.sv
module idxseq_capture
  import idxseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  kind_t           kind_i,
  input  logic [DW-1:0]   din_i,
  input  logic [AW-1:0]   idx_i,
  output logic [DW-1:0]   opcode_o,
  output logic [AW-1:0]   ea_o,
  output logic [2*DW-1:0] operand_o
);
  localparam int PAD = AW - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode_o  <= '0;
      ea_o      <= '0;
      operand_o <= '0;
    end else begin
      case (kind_i)
        K_OPC: opcode_o <= din_i;
        K_OFS: ea_o <= idx_i + {{PAD{1'b0}}, din_i};
        K_RD8: operand_o <= {{DW{1'b0}}, din_i};
        K_RDH: operand_o[2*DW-1:DW] <= din_i;
        K_RDL: operand_o[DW-1:0] <= din_i;
        default: ;
      endcase
    end
  end

  // R3
  ea_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i != K_OFS) |=> $stable(ea_o));

  // R7
  word_low_chk: assert property (@(posedge clk) disable iff (rst)
    (kind_i == K_RDL) |=> (operand_o[DW-1:0] == $past(din_i)));
endmodule

// File: rtl/idx_bus_seq.sv
module idx_bus_seq
  import idxseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [2:0]      class_i,
  input  logic [15:0]     op_addr_i,
  input  logic [15:0]     index_i,
  input  logic [7:0]      acc_i,
  input  logic [7:0]      rmw_i,
  input  logic [7:0]      din_i,
  output logic [15:0]     addr_o,
  output logic            rw_o,
  output logic [7:0]      wdata_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [7:0]      opcode_o,
  output logic [15:0]     eff_addr_o,
  output logic [15:0]     operand_o
);
  localparam logic [CYC_W-1:0] C_ONE = CYC_W'(1);

  logic [CYC_W-1:0] cnt_q, cnt_nx;
  logic [CLS_W-1:0] cls_q, cls_nx;
  logic [AW-1:0]    opa_q, opa_nx, idx_q, ea_w, addr_nx;
  logic [DW-1:0]    acc_q;
  logic             accept, last_cur, last_nx, rd_nx;
  kind_t            kind_cur, kind_nx;

  assign accept = (cnt_q == '0) && start_i;

  // current cycle decode: drives capture and the end-of-instruction step
  idxseq_plan u_plan_cur (
    .cls_i (cls_q), .cyc_i (cnt_q), .kind_o (kind_cur), .last_o (last_cur)
  );

  always_comb begin
    if (cnt_q == '0) cnt_nx = accept ? C_ONE : '0;
    else             cnt_nx = last_cur ? '0 : cnt_q + C_ONE;
    cls_nx = accept ? class_i   : cls_q;
    opa_nx = accept ? op_addr_i : opa_q;
  end

  // next cycle decode: feeds the registered bus outputs
  idxseq_plan u_plan_nx (
    .cls_i (cls_nx), .cyc_i (cnt_nx), .kind_o (kind_nx), .last_o (last_nx)
  );

  idxseq_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk (clk), .rst (rst), .kind_i (kind_cur), .din_i (din_i),
    .idx_i (idx_q), .opcode_o (opcode_o), .ea_o (ea_w),
    .operand_o (operand_o)
  );

  idxseq_agen #(.AW(AW)) u_agen (
    .kind_i (kind_nx), .opa_i (opa_nx), .ea_i (ea_w),
    .addr_o (addr_nx), .rd_o (rd_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      cls_q   <= '0;
      opa_q   <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      addr_o  <= '1;
      rw_o    <= 1'b1;
      wdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      cls_q <= cls_nx;
      opa_q <= opa_nx;
      if (accept) begin
        idx_q <= index_i;
        acc_q <= acc_i;
      end
      addr_o <= addr_nx;
      rw_o   <= rd_nx;
      if (kind_nx == K_WR) wdata_o <= (cls_nx == CL_RMW) ? rmw_i : acc_q;
      else                 wdata_o <= '0;
      done_o <= last_nx;
    end
  end

  assign busy_o     = (cnt_q != '0);
  assign eff_addr_o = ea_w;

  // R2
  dummy3_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == 3'd3) |-> (addr_o == '1 && rw_o));

  // R12
  wdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rw_o |-> (wdata_o == '0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!done_o && !busy_o));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);

  // R6
  write_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !rw_o |-> (addr_o == eff_addr_o && (cnt_q == 3'd4 || cnt_q == 3'd6)));

  // R9
  test_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && cls_q == CL_TST) |-> rw_o);
endmodule

// File: tb/tb_idx_bus_seq.sv
module tb_idx_bus_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  class_i = '0;
  logic [15:0] op_addr_i = '0, index_i = '0;
  logic [7:0]  acc_i = '0, rmw_i = '0, din_i;
  logic [15:0] addr_o, eff_addr_o, operand_o;
  logic        rw_o, busy_o, done_o;
  logic [7:0]  wdata_o, opcode_o;

  logic [15:0] cur_opa = 16'h0000;
  logic [7:0]  cur_ofs = 8'h00;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  typedef struct {
    logic [15:0] a; logic rw; logic [7:0] wd; logic dn; string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  idx_bus_seq dut (
    .clk, .rst, .start_i, .class_i, .op_addr_i, .index_i, .acc_i, .rmw_i,
    .din_i, .addr_o, .rw_o, .wdata_o, .busy_o, .done_o, .opcode_o,
    .eff_addr_o, .operand_o
  );

  function automatic logic [7:0] memb(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_comb din_i = (addr_o == cur_opa + 16'd1) ? cur_ofs : memb(addr_o);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] a, input logic rw, input logic [7:0] wd,
                      input logic dn, input string tag);
    exp_t e;
    e.a = a; e.rw = rw; e.wd = wd; e.dn = dn; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares every bus cycle against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (busy_o) begin
        if (q.size() == 0) chk(0, "R11", "unexpected bus cycle", {16'h0, addr_o}, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(addr_o == e.a && rw_o == e.rw && wdata_o == e.wd && done_o == e.dn,
              e.tag, "addr/rw/wdata/done", {addr_o, rw_o, wdata_o, done_o},
              {e.a, e.rw, e.wd, e.dn});
        end
      end else begin
        chk(addr_o == 16'hFFFF && rw_o && wdata_o == 8'h00 && !done_o, "R2",
            "idle bus", {addr_o, rw_o, wdata_o, done_o}, {16'hFFFF, 1'b1, 8'h00, 1'b0});
      end
    end
  end

  // driver: called at a negedge of an idle cycle, returns at a negedge of an idle cycle
  task automatic run(input logic [2:0] cls, input logic [15:0] opa, input logic [15:0] idx,
                     input logic [7:0] ofs, input logic [7:0] acc, input logic [7:0] rmw,
                     input bit poke);
    logic [15:0] ea, ea1;
    int len;
    ea  = idx + {8'h00, ofs};
    ea1 = ea + 16'd1;
    case (cls)
      3'd1, 3'd2: len = 4;
      3'd3: len = 5;
      3'd4, 3'd5: len = 6;
      default: len = 3;
    endcase
    push(opa, 1, 0, 0, "R1");
    push(opa + 16'd1, 1, 0, 0, "R1");
    push(16'hFFFF, 1, 0, len == 3, "R2");
    case (cls)
      3'd1: push(ea, 1, 0, 1, "R5");
      3'd2: push(ea, 0, acc, 1, "R6");
      3'd3: begin push(ea, 1, 0, 0, "R7"); push(ea1, 1, 0, 1, "R7"); end
      3'd4: begin
        push(ea, 1, 0, 0, "R8"); push(16'hFFFF, 1, 0, 0, "R8"); push(ea, 0, rmw, 1, "R8");
      end
      3'd5: begin
        push(ea, 1, 0, 0, "R9"); push(16'hFFFF, 1, 0, 0, "R9"); push(16'hFFFF, 1, 0, 1, "R9");
      end
      default: ;
    endcase
    cur_opa = opa; cur_ofs = ofs;
    class_i = cls; op_addr_i = opa; index_i = idx; acc_i = acc; rmw_i = rmw;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; acc_i = ~acc; class_i = 3'd4; index_i = ~idx; op_addr_i = 16'h0BAD;
    if (poke) begin
      start_i = 1'b1;           // R11: ignored mid-instruction
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk(!busy_o, "R10", "busy after done", {31'h0, busy_o}, 0);
    chk(opcode_o == memb(opa), "R1", "opcode", {24'h0, opcode_o}, {24'h0, memb(opa)});
    chk(eff_addr_o == ea, "R3", "effective address", {16'h0, eff_addr_o}, {16'h0, ea});
    if (cls == 3'd1 || cls == 3'd4 || cls == 3'd5)
      chk(operand_o == {8'h00, memb(ea)}, "R5", "byte operand",
          {16'h0, operand_o}, {24'h0, memb(ea)});
    if (cls == 3'd3)
      chk(operand_o == {memb(ea), memb(ea1)}, "R7", "word operand",
          {16'h0, operand_o}, {16'h0, memb(ea), memb(ea1)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && operand_o == 0 && eff_addr_o == 0, "R10", "reset state",
        {busy_o, done_o, operand_o}, 0);
    run(3'd0, 16'h1000, 16'h2000, 8'h34, 8'h00, 8'h00, 0); // R4 jump
    run(3'd1, 16'h1100, 16'h3000, 8'h80, 8'h11, 8'h00, 0); // R5, unsigned offset
    run(3'd2, 16'h1200, 16'h4000, 8'hFF, 8'h5C, 8'h00, 0); // R6
    run(3'd3, 16'h1300, 16'h5000, 8'h10, 8'h00, 8'h00, 0); // R7
    run(3'd3, 16'h1400, 16'hFFF0, 8'h0F, 8'h00, 8'h00, 0); // R7 wrap FFFF->0000
    run(3'd4, 16'h1500, 16'h6000, 8'h22, 8'h00, 8'hC3, 0); // R8
    run(3'd5, 16'h1600, 16'h7000, 8'h01, 8'h00, 8'h77, 0); // R9
    run(3'd1, 16'h1700, 16'hFFF0, 8'hF0, 8'h00, 8'h00, 0); // R3 wrap to 00E0
    run(3'd7, 16'h1800, 16'h0123, 8'h45, 8'h00, 8'h00, 0); // R4 unused code
    run(3'd2, 16'h1900, 16'h8000, 8'h00, 8'hA9, 8'h00, 1); // R11 start ignored
    run(3'd4, 16'h1A00, 16'h9000, 8'h7F, 8'h00, 8'h3E, 1); // R11, R8
    repeat (2) @(negedge clk);
    chk(q.size() == 0, "R10", "leftover expected cycles", q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule